// File: doc/BRIEF.md
# SD SPI Command Engine

This block issues one SD-card command in SPI mode and collects the card's answer. A client hands it a 6-bit command index, a 32-bit argument and a request strobe. The engine selects the card, sends the six-byte command frame through a byte-wide transfer port, then clocks idle bytes until the card answers. Before it reports completion it either releases chip select and sends one trailing idle byte, or, on request, leaves the card selected so that a following data phase can continue. The bit-level SPI shifter sits behind the transfer port, and the card bring-up policy belongs to the client. Neither is part of this block.

The transfer port uses a valid/ready handshake. A byte moves in the cycle where `xferValid` and `xferReady` are both high. `xferRxByte` must hold, in that same cycle, the byte the card returned while the transmitted byte was shifted out. The engine returns the status byte, up to four extra response bytes for the interface-condition and operating-condition queries, and a timeout flag.

Top module: `sd_cmd_engine`

## Requirements
- R1: On an accepted request `csN` goes low in the next cycle, before the first transfer is offered. It stays low through the whole command frame and the poll.
- R2: For a generic command the frame is six bytes in this order: `0x40 | index`, then the argument from its most significant byte to its least significant byte, then `0x95`.
- R3: For index 8 the argument bytes are replaced by `00 00 01 AA` and the last byte is `0x87`, whatever `reqArg` holds.
- R4: After the frame the engine sends `0xFF` on every transfer. The first received byte with bit 7 clear is returned on `r1Out`.
- R5: If `POLL_LIMIT` poll bytes all have bit 7 set, the engine sets `timedOut`, sets `r1Out` to `0xFF` and raises `csN`. It then sends exactly one `0xFF` and completes. This happens even when keep-selected mode was requested.
- R6: For index 8 and index 58 the four bytes received right after the status byte are packed most significant first into `extOut`. For every other index, and after a timeout, `extOut` is 0.
- R7: On normal completion without keep-selected mode, `csN` goes high and one `0xFF` is sent with `csN` high. No other transfer is made with `csN` high.
- R8: With `reqKeepSel` high, the engine completes straight after the status byte (and the extra bytes, if any). It sends no trailing byte, and `csN` stays low after `done`.
- R9: After reset `csN` is high, `reqReady` is high and no transfer is offered. A request is taken only while `reqReady` is high, and `reqValid` has no effect while a command is in progress. `done` is a single-cycle pulse.
- R10: While `xferValid` is high and `xferReady` is low, `xferValid` and `xferTxByte` hold their values. Stalls on the port do not change the byte sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Command request strobe |
| reqReady | output | 1 | Engine idle, request can be taken |
| reqIndex | input | 6 | Command index |
| reqArg | input | 32 | Command argument |
| reqKeepSel | input | 1 | Leave card selected after the status byte |
| done | output | 1 | One-cycle completion pulse |
| r1Out | output | 8 | Status byte (0xFF after timeout) |
| extOut | output | 32 | Extra response bytes, first received in bits 31:24 |
| timedOut | output | 1 | Last command got no status byte |
| csN | output | 1 | Card chip select, active low |
| xferValid | output | 1 | Transfer byte offered |
| xferReady | input | 1 | Shifter takes the byte this cycle |
| xferTxByte | output | 8 | Byte to send |
| xferRxByte | input | 8 | Byte received in the same transfer |

## Verification
The bench builds the engine with `POLL_LIMIT` = 8. This makes the timeout path and its boundary (a status byte arriving on the last allowed poll, against none arriving at all) reachable within a few dozen cycles, instead of after thousands of idle bytes. The other parameters keep their defaults, so the real command codes 8 and 58 and the fixed 0x95 check byte are exercised. Alternate table entries run with a stalling ready pattern, so the same sequences are also checked across handshake gaps.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_POLL,
    ST_EXT,
    ST_TAIL
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;        // latch a new request
    logic sendFrame;   // drive frame byte instead of idle fill
    logic cntClr;
    logic cntInc;
    logic capR1;
    logic capExt;
    logic markTimeout;
  } dp_ctl_t;

  // conditions from datapath to control
  typedef struct packed {
    logic cmdLast;
    logic extLast;
    logic pollLast;
    logic wantExt;
  } dp_sts_t;

  localparam logic [7:0] IDLE_FILL = 8'hFF;

endpackage

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
#(
  parameter int          POLL_LIMIT  = 5000,
  parameter int          CMD_W       = 6,
  parameter int          ARG_W       = 32,
  parameter int          EXT_W       = 32,
  parameter logic [7:0]  GENERIC_CRC = 8'h95,
  parameter logic [7:0]  CHK_CRC     = 8'h87,
  parameter int          CHK_INDEX   = 8,
  parameter int          OCR_INDEX   = 58,
  parameter logic [31:0] CHK_ARG     = 32'h0000_01AA
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_ctl_t          ctl,
  output dp_sts_t          sts,
  input  logic [CMD_W-1:0] reqIndex,
  input  logic [ARG_W-1:0] reqArg,
  input  logic [7:0]       rxByte,
  output logic [7:0]       txByte,
  output logic [7:0]       r1Out,
  output logic [EXT_W-1:0] extOut,
  output logic             timedOut
);

  localparam int ARG_BYTES = ARG_W / 8;
  localparam int EXT_BYTES = EXT_W / 8;
  localparam int CNT_RAW   = $clog2(POLL_LIMIT + 1);
  localparam int CNT_W     = (CNT_RAW > 3) ? CNT_RAW : 3;
  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(ARG_BYTES + 1);
  localparam logic [CNT_W-1:0] EXT_LAST  = CNT_W'(EXT_BYTES - 1);
  localparam logic [CNT_W-1:0] POLL_LAST = CNT_W'(POLL_LIMIT - 1);

  logic [CMD_W-1:0] idxQ;
  logic [ARG_W-1:0] argQ;
  logic [7:0]       crcQ;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       r1Q;
  logic [EXT_W-1:0] extQ;
  logic             toQ;
  logic             isChk;
  logic [7:0]       frameByte;

  assign isChk = (reqIndex == CMD_W'(CHK_INDEX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ <= '0;
      argQ <= '0;
      crcQ <= GENERIC_CRC;
    end else if (ctl.load) begin
      idxQ <= reqIndex;
      argQ <= isChk ? ARG_W'(CHK_ARG) : reqArg;
      crcQ <= isChk ? CHK_CRC : GENERIC_CRC;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc)     cnt <= cnt + 1'b1;
  end

  // byte select within the command frame
  always_comb begin
    frameByte = IDLE_FILL;
    if (cnt == '0) begin
      frameByte = {2'b01, idxQ};
    end else if (cnt == CMD_LAST) begin
      frameByte = crcQ;
    end else begin
      for (int b = 0; b < ARG_BYTES; b++) begin
        if (cnt == CNT_W'(b + 1)) frameByte = argQ[ARG_W-1-8*b -: 8];
      end
    end
  end

  assign txByte = ctl.sendFrame ? frameByte : IDLE_FILL;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      r1Q  <= 8'hFF;
      extQ <= '0;
      toQ  <= 1'b0;
    end else begin
      if (ctl.load) begin
        extQ <= '0;
        toQ  <= 1'b0;
      end
      if (ctl.capR1)  r1Q  <= rxByte;
      if (ctl.capExt) extQ <= {extQ[EXT_W-9:0], rxByte};
      if (ctl.markTimeout) begin
        r1Q <= 8'hFF;
        toQ <= 1'b1;
      end
    end
  end

  assign sts.cmdLast  = (cnt == CMD_LAST);
  assign sts.extLast  = (cnt == EXT_LAST);
  assign sts.pollLast = (cnt == POLL_LAST);
  assign sts.wantExt  = (idxQ == CMD_W'(CHK_INDEX)) || (idxQ == CMD_W'(OCR_INDEX));

  assign r1Out    = r1Q;
  assign extOut   = extQ;
  assign timedOut = toQ;

  // R4: a captured status byte never carries bit 7
  p_r1_bit7_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capR1 && !ctl.markTimeout |=> !r1Q[7]);

  // R6: extra bytes are only shifted in for the two query commands
  p_ext_only_query_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capExt |-> sts.wantExt);

endmodule

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqKeepSel,
  output logic    reqReady,
  output logic    done,
  output logic    csN,
  output logic    xferValid,
  input  logic    xferReady,
  input  logic    rxBit7,
  input  dp_sts_t sts,
  output dp_ctl_t ctl
);

  state_t state, stateNx;
  logic   csNQ, csNNx;
  logic   keepQ;
  logic   doneQ, doneNx;
  logic   fire;

  assign fire      = xferValid && xferReady;
  assign reqReady  = (state == ST_IDLE);
  assign xferValid = (state != ST_IDLE);

  always_comb begin
    stateNx = state;
    csNNx   = csNQ;
    doneNx  = 1'b0;
    ctl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.load   = 1'b1;
          ctl.cntClr = 1'b1;
          csNNx      = 1'b0;
          stateNx    = ST_CMD;
        end
      end
      ST_CMD: begin
        ctl.sendFrame = 1'b1;
        if (fire) begin
          if (sts.cmdLast) begin
            ctl.cntClr = 1'b1;
            stateNx    = ST_POLL;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_POLL: begin
        if (fire) begin
          if (!rxBit7) begin
            ctl.capR1  = 1'b1;
            ctl.cntClr = 1'b1;
            if (sts.wantExt) begin
              stateNx = ST_EXT;
            end else if (keepQ) begin
              stateNx = ST_IDLE;
              doneNx  = 1'b1;
            end else begin
              stateNx = ST_TAIL;
              csNNx   = 1'b1;
            end
          end else if (sts.pollLast) begin
            ctl.markTimeout = 1'b1;
            stateNx         = ST_TAIL;
            csNNx           = 1'b1;
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_EXT: begin
        if (fire) begin
          ctl.capExt = 1'b1;
          if (sts.extLast) begin
            if (keepQ) begin
              stateNx = ST_IDLE;
              doneNx  = 1'b1;
            end else begin
              stateNx = ST_TAIL;
              csNNx   = 1'b1;
            end
          end else begin
            ctl.cntInc = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (fire) begin
          stateNx = ST_IDLE;
          doneNx  = 1'b1;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      csNQ  <= 1'b1;
      keepQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      state <= stateNx;
      csNQ  <= csNNx;
      doneQ <= doneNx;
      if (ctl.load) keepQ <= reqKeepSel;
    end
  end

  assign csN  = csNQ;
  assign done = doneQ;

  // R1: card is selected while the frame goes out
  p_cs_low_frame_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CMD || state == ST_POLL) |-> !csNQ);

  // R7: the trailing byte always goes out with the card released
  p_tail_released_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TAIL) |-> csNQ);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int POLL_LIMIT = 5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [5:0]  reqIndex,
  input  logic [31:0] reqArg,
  input  logic        reqKeepSel,
  output logic        done,
  output logic [7:0]  r1Out,
  output logic [31:0] extOut,
  output logic        timedOut,
  output logic        csN,
  output logic        xferValid,
  input  logic        xferReady,
  output logic [7:0]  xferTxByte,
  input  logic [7:0]  xferRxByte
);

  dp_ctl_t ctl;
  dp_sts_t sts;

  sd_cmd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqKeepSel (reqKeepSel),
    .reqReady   (reqReady),
    .done       (done),
    .csN        (csN),
    .xferValid  (xferValid),
    .xferReady  (xferReady),
    .rxBit7     (xferRxByte[7]),
    .sts        (sts),
    .ctl        (ctl)
  );

  sd_cmd_dp #(
    .POLL_LIMIT (POLL_LIMIT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .sts      (sts),
    .reqIndex (reqIndex),
    .reqArg   (reqArg),
    .rxByte   (xferRxByte),
    .txByte   (xferTxByte),
    .r1Out    (r1Out),
    .extOut   (extOut),
    .timedOut (timedOut)
  );

  // R10: an offered byte holds until it is taken
  p_hold_offer_r10: assert property (@(posedge clk) disable iff (!rstN)
    xferValid && !xferReady |=> xferValid && $stable(xferTxByte));

  // R5: a timeout always ends with the card released
  p_timeout_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    done && timedOut |-> csN && r1Out == 8'hFF);

  // R4: a completed non-timeout command reports a status byte with bit 7 clear
  p_status_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    done && !timedOut |-> !r1Out[7]);

endmodule

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;

  localparam int LIMIT = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [5:0]  reqIndex = '0;
  logic [31:0] reqArg = '0;
  logic        reqKeepSel = 1'b0;
  logic        done;
  logic [7:0]  r1Out;
  logic [31:0] extOut;
  logic        timedOut;
  logic        csN;
  logic        xferValid;
  logic        xferReady = 1'b1;
  logic [7:0]  xferTxByte;
  logic [7:0]  xferRxByte;

  always #5 clk = ~clk;

  sd_cmd_engine #(.POLL_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIndex(reqIndex), .reqArg(reqArg), .reqKeepSel(reqKeepSel),
    .done(done), .r1Out(r1Out), .extOut(extOut), .timedOut(timedOut),
    .csN(csN), .xferValid(xferValid), .xferReady(xferReady),
    .xferTxByte(xferTxByte), .xferRxByte(xferRxByte)
  );

  int nChk = 0;
  int nFail = 0;

  // card model: scripted receive bytes and a log of each transfer
  logic [7:0] rxScript [64];
  logic [7:0] txLog [64];
  logic       csLog [64];
  int         rxPtr = 0;
  int         txN = 0;
  logic       logClr = 1'b0;
  logic       stallMode = 1'b0;
  int         cyc = 0;

  assign xferRxByte = (rxPtr < 64) ? rxScript[rxPtr] : 8'hFF;

  always @(posedge clk) begin
    if (logClr) begin
      txN   <= 0;
      rxPtr <= 0;
    end else if (xferValid && xferReady) begin
      if (txN < 64) begin
        txLog[txN] <= xferTxByte;
        csLog[txN] <= csN;
      end
      txN   <= txN + 1;
      rxPtr <= rxPtr + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    xferReady <= stallMode ? ((cyc % 3) != 1) : 1'b1;
  end

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", nChk + 1 - nFail, nChk + 1);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] expFrame(input logic [5:0] idx,
                                          input logic [31:0] arg, input int i);
    logic [31:0] a;
    a = (idx == 6'd8) ? 32'h0000_01AA : arg;
    case (i)
      0: return {2'b01, idx};
      1: return a[31:24];
      2: return a[23:16];
      3: return a[15:8];
      4: return a[7:0];
      default: return (idx == 6'd8) ? 8'h87 : 8'h95;
    endcase
  endfunction

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic        keep;
    logic [7:0]  delay;
    logic [7:0]  r1;
    logic [31:0] ext;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{6'd0,  32'h0000_0000, 1'b0, 8'd1, 8'h01, 32'h0},
    '{6'd8,  32'hDEAD_BEEF, 1'b0, 8'd0, 8'h01, 32'h0000_01AA},
    '{6'd58, 32'h0000_0000, 1'b0, 8'd3, 8'h00, 32'hC0FF_8000},
    '{6'd17, 32'h1234_5678, 1'b0, 8'd7, 8'h00, 32'h0},
    '{6'd24, 32'hA5A5_0F0F, 1'b0, 8'd8, 8'h00, 32'h0},
    '{6'd9,  32'h0000_0000, 1'b1, 8'd2, 8'h00, 32'h0},
    '{6'd55, 32'h0000_0000, 1'b0, 8'd0, 8'h05, 32'h0},
    '{6'd41, 32'h4000_0000, 1'b0, 8'd4, 8'h7E, 32'h0},
    '{6'd58, 32'h0000_0000, 1'b1, 8'd8, 8'h00, 32'h1122_3344},
    '{6'd8,  32'h0000_0000, 1'b1, 8'd1, 8'h01, 32'h0000_01AA}
  };

  task automatic loadScript(input vec_t v);
    int p;
    for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
    p = 6 + int'(v.delay);
    if (p < 64) rxScript[p] = v.r1;
    for (int k = 0; k < 4; k++) if (p + 1 + k < 64) rxScript[p + 1 + k] = v.ext[31-8*k -: 8];
    @(negedge clk); logClr = 1'b1;
    @(negedge clk); logClr = 1'b0;
  endtask

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic keep);
    @(negedge clk);
    reqIndex = idx; reqArg = arg; reqKeepSel = keep; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic runVec(input vec_t v, input int n);
    bit   seen, to, wantExt, tail, frameOk, csOk;
    int   polls, expN;
    logic [31:0] expExt;
    string tag;
    loadScript(v);
    issue(v.idx, v.arg, v.keep);
    waitDone(seen);
    check(seen, "R9", $sformatf("vec%0d done seen", n), seen, 1);
    to      = (v.delay >= LIMIT);
    wantExt = (v.idx == 6'd8) || (v.idx == 6'd58);
    polls   = to ? LIMIT : int'(v.delay) + 1;
    tail    = to || !v.keep;
    expN    = 6 + polls + ((wantExt && !to) ? 4 : 0) + (tail ? 1 : 0);
    expExt  = (wantExt && !to) ? v.ext : 32'h0;
    tag     = stallMode ? "R10" : "R2";
    frameOk = 1'b1;
    for (int i = 0; i < 6; i++) if (txLog[i] !== expFrame(v.idx, v.arg, i)) frameOk = 1'b0;
    check(frameOk, (v.idx == 6'd8) ? "R3" : tag, $sformatf("vec%0d frame bytes", n),
          {txLog[0], txLog[5]}, {expFrame(v.idx, v.arg, 0), expFrame(v.idx, v.arg, 5)});
    check(txN == expN, to ? "R5" : "R4", $sformatf("vec%0d transfer count", n), txN, expN);
    check(timedOut == to, "R5", $sformatf("vec%0d timeout flag", n), timedOut, to);
    check(r1Out == (to ? 8'hFF : v.r1), "R4", $sformatf("vec%0d status byte", n),
          r1Out, to ? 8'hFF : v.r1);
    check(extOut == expExt, "R6", $sformatf("vec%0d extra bytes", n), extOut, expExt);
    csOk = 1'b1;
    for (int i = 0; i < expN && i < 64; i++) begin
      if (csLog[i] !== (tail && i == expN - 1)) csOk = 1'b0;
      if (i >= 6 && txLog[i] !== 8'hFF) csOk = 1'b0;
    end
    check(csOk, tail ? "R7" : "R8", $sformatf("vec%0d select/fill pattern", n), csOk, 1);
    check(csN == tail, tail ? "R7" : "R8", $sformatf("vec%0d csN after done", n), csN, tail);
    @(negedge clk);
    check(!done, "R9", $sformatf("vec%0d done one cycle", n), done, 0);
  endtask

  initial begin
    bit seen;
    vec_t vb;
    for (int i = 0; i < 64; i++) rxScript[i] = 8'hFF;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(csN && reqReady && !xferValid && !done && !timedOut, "R9", "reset state",
          {csN, reqReady, xferValid, done, timedOut}, 5'b11000);
    rstN = 1'b1;
    @(negedge clk);
    issue(6'd0, 32'h0, 1'b0);
    // R1: select is low right after acceptance, before any byte moves
    check(!csN && txN == 0, "R1", "select before first byte", {csN, txN[7:0]}, 0);
    waitDone(seen);
    @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      stallMode = n[0];
      runVec(VECS[n], n);
    end
    stallMode = 1'b0;

    // R9: requests during a command are ignored
    vb = '{6'd13, 32'h0000_0000, 1'b0, 8'd5, 8'h00, 32'h0};
    loadScript(vb);
    issue(vb.idx, vb.arg, 1'b0);
    for (int i = 0; i < 9; i++) @(negedge clk);
    reqIndex = 6'd63; reqArg = 32'hFFFF_FFFF; reqValid = 1'b1;
    @(negedge clk); @(negedge clk);
    reqValid = 1'b0;
    waitDone(seen);
    check(txN == 6 + 6 + 1, "R9", "busy request ignored, count", txN, 13);
    check(txLog[0] == 8'h4D && txLog[1] == 8'h00, "R9", "busy request ignored, frame",
          {txLog[0], txLog[1]}, 16'h4D00);
    for (int i = 0; i < 10; i++) @(negedge clk);
    check(reqReady && !xferValid && csN, "R9", "idle after completion",
          {reqReady, xferValid, csN}, 3'b101);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule